// File: doc/BRIEF.md
# Ring Trip and Hook Supervisor

This block supervises one subscriber line on the digital side. It takes a raw loop-current-detect bit, resynchronises it, and qualifies every change of state over a number of millisecond ticks. The result is a switch-hook output and an LED drive, both low while the line is off-hook. Short breaks and makes are qualified the same way, so dial pulses reach the hook output as long as each half of a pulse outlasts the qualify time.

A ring request input drives the ringing relay. While the relay is closed, and for a guard interval after it opens, a ringing filter replaces the normal hook qualify time with a longer ring-trip window. This keeps AC ringing current and switching transients from reading as an answer. When an off-hook is qualified during ringing, the relay opens on its own. It stays open until the request has been withdrawn and raised again. All timing is counted in ticks of an external 1 ms strobe.

Top module: `ring_hook_supervisor`

## Requirements
- R1: In reset and on the first cycle after it, `hook_n` and `led_n` are 1 (on-hook) and `ring_relay_en` is 0.
- R2: With the filter inactive, a detect level of 1 (loop current present) that lasts through `DEBOUNCE_MS` consecutive ticks drives `hook_n` to 0. The output changes only on a tick edge.
- R3: With the filter inactive, a detect level of 0 that lasts through `DEBOUNCE_MS` consecutive ticks returns `hook_n` to 1.
- R4: A detect level that disagrees with the qualified state for fewer ticks than the applicable limit leaves `hook_n` unchanged. Any return to agreement restarts the count from zero.
- R5: `led_n` equals `hook_n` in every cycle.
- R6: A cycle in which `ring_req` is 1 while the sequencer is idle and the line is on-hook closes the relay: `ring_relay_en` is 1 from the next cycle.
- R7: While the filter is active, a change needs `TRIP_MS` consecutive ticks. A disagreement of at least `DEBOUNCE_MS` but fewer than `TRIP_MS` ticks leaves `hook_n` unchanged.
- R8: A qualified off-hook while the relay is closed opens the relay in the cycle after `hook_n` falls.
- R9: After a ring trip the relay stays open while `ring_req` stays 1. A 0 followed by a 1 on `ring_req` is needed before ringing can start again.
- R10: The filter stays active for `GUARD_MS` ticks after the relay opens. A tick on which the guard count is non-zero still uses the `TRIP_MS` limit, and later ticks use `DEBOUNCE_MS`.
- R11: `ring_req` at 0 in any cycle makes `ring_relay_en` 0 from the next cycle.
- R12: A ring request that arrives while the line is already qualified off-hook does not close the relay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loop_det_raw | input | 1 | Raw loop-current detect, 1 means current flows; asynchronous |
| ring_req | input | 1 | Ringing request, synchronous to clk |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| hook_n | output | 1 | Qualified switch-hook, 0 means off-hook |
| led_n | output | 1 | LED drive, 0 means off-hook |
| ring_relay_en | output | 1 | Ringing relay drive, 1 closes the relay |

## Verification
The ring-trip qualification and the withdrawal of the ring request can both end the ringing state on the same clock edge. The final qualifying tick removes the relay by way of the hook state, while the falling request removes it directly, and each path also loads the guard count. The bench provokes the collision by lowering `ring_req` on the same cycle as the tick that completes the trip window. It then expects `hook_n` low and the relay open, and it expects a fresh request on the still off-hook line to leave the relay open. A sweep of guard ticks consumed before an off-hook shows where the switch from the trip limit back to the debounce limit takes effect.

// File: rtl/hooksup_pkg.sv
// Package: shared types and width helper for the ring/hook supervisor.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time functions.
package hooksup_pkg;

    // Ringing sequencer states.
    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_RINGING = 2'd1,
        RS_TRIPPED = 2'd2
    } ring_state_e;

    // Width of a counter that must hold values 0..n (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/det_sync.sv
// det_sync: multi-stage synchroniser for the raw loop-detect bit.
// Assumes the input may change at any time relative to clk; the reset
// value 0 stands for "no loop current" so the line starts on-hook.
module det_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hook_qualifier.sv
// hook_qualifier: holds the qualified off-hook state and flips it only after
// the synchronised detect disagrees with it for a whole qualify window.
// The window is DEBOUNCE_MS ticks normally and TRIP_MS ticks while
// filter_on is high. Assumes TRIP_MS >= DEBOUNCE_MS >= 1.
module hook_qualifier
    import hooksup_pkg::*;
#(
    parameter int DEBOUNCE_MS = 20,
    parameter int TRIP_MS     = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det,
    input  logic ms_tick,
    input  logic filter_on,
    output logic offhook
);
    localparam int CNT_W = cnt_width(TRIP_MS);
    localparam logic [CNT_W:0] LIM_DEB  = DEBOUNCE_MS[CNT_W:0];
    localparam logic [CNT_W:0] LIM_TRIP = TRIP_MS[CNT_W:0];

    logic             offhook_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   limit;
    logic [CNT_W:0]   run_next;
    logic             differs;
    logic             expire;

    // Select the qualify window and judge whether this tick completes it.
    always_comb begin
        limit    = filter_on ? LIM_TRIP : LIM_DEB;
        differs  = (det != offhook_q);
        run_next = {1'b0, run_q} + 1'b1;
        expire   = differs && ms_tick && (run_next >= limit);
    end

    // Count disagreeing ticks and flip the state when the window is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offhook_q <= 1'b0;
            run_q     <= '0;
        end else if (!differs) begin
            run_q     <= '0;
        end else if (expire) begin
            offhook_q <= ~offhook_q;
            run_q     <= '0;
        end else if (ms_tick) begin
            run_q     <= run_next[CNT_W-1:0];
        end
    end

    assign offhook = offhook_q;

    // R2: the qualified state changes only on a tick edge.
    assert_flip_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (offhook_q != $past(offhook_q)) |-> $past(ms_tick));

    // R4: a flip needs a disagreeing detect level in the cycle before.
    assert_flip_needs_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (offhook_q != $past(offhook_q)) |-> ($past(det) != $past(offhook_q)));

    // R7: the run count never reaches the longest window.
    assert_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, run_q} < LIM_TRIP));

endmodule

// File: rtl/ring_sequencer.sv
// ring_sequencer: closes the ringing relay on a fresh request, opens it on
// request withdrawal or ring trip, and keeps the ringing filter active for
// a guard interval after the relay opens. Assumes ring_req is synchronous.
module ring_sequencer
    import hooksup_pkg::*;
#(
    parameter int GUARD_MS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_req,
    input  logic ms_tick,
    input  logic offhook,
    output logic relay_en,
    output logic filter_on
);
    localparam int GRD_W = cnt_width(GUARD_MS);
    localparam logic [GRD_W-1:0] GUARD_LOAD = GUARD_MS[GRD_W-1:0];

    ring_state_e      state_q;
    ring_state_e      state_d;
    logic [GRD_W-1:0] guard_q;
    logic             leave_ring;

    // Next-state decision for the ringing sequence.
    always_comb begin
        state_d    = state_q;
        leave_ring = 1'b0;
        case (state_q)
            RS_IDLE: begin
                if (ring_req) state_d = offhook ? RS_TRIPPED : RS_RINGING;
            end
            RS_RINGING: begin
                if (!ring_req) begin
                    state_d    = RS_IDLE;
                    leave_ring = 1'b1;
                end else if (offhook) begin
                    state_d    = RS_TRIPPED;
                    leave_ring = 1'b1;
                end
            end
            RS_TRIPPED: begin
                if (!ring_req) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Guard countdown: load on leaving ringing, count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                        guard_q <= '0;
        else if (leave_ring)               guard_q <= GUARD_LOAD;
        else if (ms_tick && guard_q != '0) guard_q <= guard_q - 1'b1;
    end

    assign relay_en  = (state_q == RS_RINGING);
    assign filter_on = relay_en || (guard_q != '0);

    // R6: the relay closes only after a request on an on-hook line.
    assert_close_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_en) |-> ($past(ring_req) && !$past(offhook)));

    // R8: a qualified off-hook during ringing opens the relay next cycle.
    assert_trip_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (relay_en && offhook) |=> !relay_en);

    // R9: after a trip the relay stays open while the request is held.
    assert_no_rering_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_TRIPPED && ring_req) |=> !relay_en);

    // R10: the guard count is full when the relay has just opened.
    assert_guard_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(relay_en) |-> (guard_q == GUARD_LOAD));

    // R11: withdrawing the request opens the relay next cycle.
    assert_withdraw_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_req |=> !relay_en);

endmodule

// File: rtl/ring_hook_supervisor.sv
// ring_hook_supervisor: top of the line supervisor. Synchronises the raw
// loop detect, qualifies hook state with a window that the ringing filter
// lengthens, and runs the ringing relay with automatic ring trip.
// Assumes ms_tick is a one-cycle strobe and ring_req is synchronous to clk.
module ring_hook_supervisor #(
    parameter int DEBOUNCE_MS = 20,
    parameter int TRIP_MS     = 110,
    parameter int GUARD_MS    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_det_raw,
    input  logic ring_req,
    input  logic ms_tick,
    output logic hook_n,
    output logic led_n,
    output logic ring_relay_en
);
    logic det_s;
    logic offhook;
    logic filter_on;

    det_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (loop_det_raw),
        .d_sync  (det_s)
    );

    hook_qualifier #(
        .DEBOUNCE_MS (DEBOUNCE_MS),
        .TRIP_MS     (TRIP_MS)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .det       (det_s),
        .ms_tick   (ms_tick),
        .filter_on (filter_on),
        .offhook   (offhook)
    );

    ring_sequencer #(
        .GUARD_MS (GUARD_MS)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_req  (ring_req),
        .ms_tick   (ms_tick),
        .offhook   (offhook),
        .relay_en  (ring_relay_en),
        .filter_on (filter_on)
    );

    assign hook_n = ~offhook;
    assign led_n  = ~offhook;

endmodule

// File: tb/ring_hook_supervisor_test.sv
module ring_hook_supervisor_test;
    localparam int DEB = 3;
    localparam int TRIP = 7;
    localparam int GUARD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_det_raw = 1'b0;
    logic ring_req = 1'b0;
    logic ms_tick = 1'b0;
    logic hook_n, led_n, ring_relay_en;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ring_hook_supervisor #(
        .DEBOUNCE_MS (DEB),
        .TRIP_MS     (TRIP),
        .GUARD_MS    (GUARD),
        .SYNC_STAGES (2)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .loop_det_raw  (loop_det_raw),
        .ring_req      (ring_req),
        .ms_tick       (ms_tick),
        .hook_n        (hook_n),
        .led_n         (led_n),
        .ring_relay_en (ring_relay_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
        idle(3);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Return the line to on-hook, no ringing, guard expired.
    task automatic restore();
        ring_req = 1'b0;
        loop_det_raw = 1'b0;
        idle(4);
        ticks(TRIP + GUARD + 2);
        chk("R3 restore", hook_n, 1'b1);
    endtask

    // First tick index at which an off-hook is qualified when rem guard ticks remain.
    function automatic int flip_tick(input int rem);
        for (int j = 1; j < 100; j++)
            if (j >= ((j <= rem) ? TRIP : DEB)) return j;
        return 100;
    endfunction

    initial begin
        idle(3);
        chk("R1 hook", hook_n, 1'b1);
        chk("R1 led", led_n, 1'b1);
        chk("R1 relay", ring_relay_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hook after release", hook_n, 1'b1);
        chk("R1 relay after release", ring_relay_en, 1'b0);

        // Normal-mode burst sweep: R2, R3, R4, R5.
        for (int k = 1; k <= TRIP + 1; k++) begin
            loop_det_raw = 1'b1;
            idle(4);
            ticks(k);
            chk((k >= DEB) ? "R2 burst" : "R4 short burst", hook_n, (k >= DEB) ? 1'b0 : 1'b1);
            chk("R5 led", led_n, hook_n);
            loop_det_raw = 1'b0;
            idle(4);
            if (k >= DEB) begin
                ticks(DEB - 1);
                chk("R4 early release", hook_n, 1'b0);
                tick();
                chk("R3 release", hook_n, 1'b1);
                chk("R5 led", led_n, hook_n);
            end
        end

        // Dial-pulse train: breaks and makes each DEB ticks long (R2, R3).
        for (int p = 0; p < 3; p++) begin
            loop_det_raw = 1'b1; idle(4); ticks(DEB);
            chk("R2 pulse make", hook_n, 1'b0);
            loop_det_raw = 1'b0; idle(4); ticks(DEB);
            chk("R3 pulse break", hook_n, 1'b1);
        end

        // Glitch restart: DEB-1 ticks, gap, DEB-1 ticks stays on-hook (R4).
        loop_det_raw = 1'b1; idle(4); ticks(DEB - 1);
        loop_det_raw = 1'b0; idle(4);
        loop_det_raw = 1'b1; idle(4); ticks(DEB - 1);
        chk("R4 restart", hook_n, 1'b1);
        loop_det_raw = 1'b0; idle(4);

        // Ringing sweep: R6, R7, R8, R9, R11, R12.
        for (int k = 1; k <= TRIP + 1; k++) begin
            ring_req = 1'b1;
            idle(2);
            chk("R6 relay closes", ring_relay_en, 1'b1);
            loop_det_raw = 1'b1;
            idle(4);
            ticks(k);
            chk((k >= TRIP) ? "R8 trip hook" : "R7 filtered", hook_n, (k >= TRIP) ? 1'b0 : 1'b1);
            chk((k >= TRIP) ? "R8 trip relay" : "R7 still ringing", ring_relay_en, (k >= TRIP) ? 1'b0 : 1'b1);
            if (k >= TRIP) begin
                idle(6);
                chk("R9 held request", ring_relay_en, 1'b0);
                ring_req = 1'b0; idle(2);
                ring_req = 1'b1; idle(3);
                chk("R12 request off-hook", ring_relay_en, 1'b0);
                restore();
                ring_req = 1'b1; idle(2);
                chk("R9 re-armed", ring_relay_en, 1'b1);
                ring_req = 1'b0; idle(2);
                chk("R11 withdraw", ring_relay_en, 1'b0);
                restore();
            end else begin
                loop_det_raw = 1'b0;
                idle(4);
                ring_req = 1'b0;
                idle(2);
                chk("R11 withdraw", ring_relay_en, 1'b0);
                restore();
            end
        end

        // Guard sweep: R10.
        for (int g = 0; g <= GUARD + 1; g++) begin
            int rem;
            int e;
            ring_req = 1'b1; idle(2);
            ring_req = 1'b0; idle(3);
            ticks(g);
            rem = (GUARD > g) ? GUARD - g : 0;
            e = flip_tick(rem);
            loop_det_raw = 1'b1;
            idle(4);
            for (int j = 1; j <= e; j++) begin
                tick();
                if (j == e - 1 || j == e)
                    chk("R10 guard window", hook_n, (j < e) ? 1'b1 : 1'b0);
            end
            restore();
        end

        // Same-cycle trip completion and request withdrawal (R8, R11, R12).
        ring_req = 1'b1; idle(2);
        loop_det_raw = 1'b1; idle(4);
        ticks(TRIP - 1);
        chk("R7 before final tick", hook_n, 1'b1);
        @(negedge clk) begin ms_tick = 1'b1; ring_req = 1'b0; end
        @(negedge clk) ms_tick = 1'b0;
        idle(3);
        chk("R8 collision hook", hook_n, 1'b0);
        chk("R11 collision relay", ring_relay_en, 1'b0);
        ring_req = 1'b1; idle(3);
        chk("R12 collision re-request", ring_relay_en, 1'b0);
        restore();

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule